// File: doc/BRIEF.md
# Partial-Width Merging Register File

This block holds sixteen 64-bit general-purpose registers for an integer datapath. A register can be accessed in four widths: the whole 64-bit word, the low 32 bits, the low 16 bits, or the low byte. On the first four registers, bits 15:8 can also be accessed as a byte of their own, called the upper byte lane.

There are two combinational read ports and one write port that updates on the clock edge. Each port takes a register index, a 2-bit width code and an upper-byte flag. A write is merged into the stored word. The rules depend on the width. A 32-bit write zero-fills the upper half of the word. A 16-bit write or a byte write leaves every bit outside its field unchanged. A read returns the selected field zero-extended to 64 bits.

A request for the upper byte lane on a register that lacks one is refused. For a write, the register is left unchanged and a one-cycle error pulse is raised.

Top module: `prf_regfile`

## Requirements
- R1: An asynchronous active-low reset (`rst_n` low) clears all sixteen registers to zero at once and clears `wr_err`.
- R2: A write with width code 2'b11 replaces all 64 bits of the addressed register.
- R3: A write with width code 2'b10 loads bits 31:0 from `wr_data[31:0]` and forces bits 63:32 to zero.
- R4: A write with width code 2'b01 loads bits 15:0 from `wr_data[15:0]` and keeps bits 63:16 unchanged.
- R5: A write with width code 2'b00 and `wr_hi` low loads bits 7:0 from `wr_data[7:0]` and keeps every other bit.
- R6: A write with width code 2'b00 and `wr_hi` high to register 0, 1, 2 or 3 loads bits 15:8 from `wr_data[7:0]` and keeps every other bit.
- R7: A write with width code 2'b00 and `wr_hi` high to registers 4 to 15 leaves the register unchanged. `wr_err` is then high for exactly the one cycle after that clock edge, and it is low after every other write.
- R8: A read returns the selected field zero-extended to 64 bits: code 2'b00 gives bits 7:0, 2'b01 gives bits 15:0, 2'b10 gives bits 31:0 and 2'b11 gives all 64 bits.
- R9: A read with width code 2'b00 and the upper-byte flag high returns bits 15:8 of the register in output bits 7:0 for registers 0 to 3, and returns zero for registers 4 to 15.
- R10: A read of the register being written returns the old value until the clock edge. The merged value is visible from that edge on.
- R11: The two read ports are independent. Each returns its own register and width in the same cycle.
- R12: The upper-byte flags (`wr_hi`, `rd0_hi`, `rd1_hi`) have no effect when the width code is not 2'b00.
- R13: With `wr_en` low, no register changes and `wr_err` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Write register index |
| wr_size | input | 2 | Write width code |
| wr_hi | input | 1 | Write targets bits 15:8 |
| wr_data | input | 64 | Write data, low-aligned |
| wr_err | output | 1 | Upper-byte write refused, one cycle |
| rd0_idx | input | 4 | Read port 0 index |
| rd0_size | input | 2 | Read port 0 width code |
| rd0_hi | input | 1 | Read port 0 upper-byte flag |
| rd0_data | output | 64 | Read port 0 zero-extended data |
| rd1_idx | input | 4 | Read port 1 index |
| rd1_size | input | 2 | Read port 1 width code |
| rd1_hi | input | 1 | Read port 1 upper-byte flag |
| rd1_data | output | 64 | Read port 1 zero-extended data |

## Verification
A wrong merge leaves bad bits in storage. Those bits show on the next full-width read of that register, one clock edge after the write. A read with a narrow width can hide bad upper bits, so every write is checked with a full 64-bit read. A bad legality decision shows in two ways in the cycle after the edge: `wr_err` has the wrong value, and a register that should have been refused has changed. A fault in the read path shows at once, in the same cycle, on the affected port and width.

// File: rtl/prf_pkg.sv
package prf_pkg;
  typedef enum logic [1:0] {
    SZ_B = 2'b00,
    SZ_H = 2'b01,
    SZ_W = 2'b10,
    SZ_Q = 2'b11
  } prf_size_e;

  localparam int unsigned BYTE_BITS = 8;
  localparam int unsigned HALF_BITS = 16;
  localparam int unsigned WORD_BITS = 32;
endpackage

// File: rtl/prf_write_merge.sv
module prf_write_merge
  import prf_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned HI_REGS = 4
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       size,
  input  logic             hi,
  input  logic [XLEN-1:0]  old_val,
  input  logic [XLEN-1:0]  data,
  output logic [XLEN-1:0]  merged,
  output logic             legal
);
  localparam int unsigned B = BYTE_BITS;
  localparam int unsigned H = HALF_BITS;
  localparam int unsigned W = WORD_BITS;

  always_comb begin
    legal  = 1'b1;
    merged = old_val;
    unique case (prf_size_e'(size))
      SZ_Q: merged = data;
      SZ_W: begin
        merged      = '0;
        merged[W-1:0] = data[W-1:0];
      end
      SZ_H: merged[H-1:0] = data[H-1:0];
      SZ_B: begin
        if (hi) begin
          if (int'(idx) < int'(HI_REGS)) merged[H-1:B] = data[B-1:0];
          else legal = 1'b0;
        end else begin
          merged[B-1:0] = data[B-1:0];
        end
      end
      default: merged = old_val;
    endcase
  end
endmodule

// File: rtl/prf_read_port.sv
module prf_read_port
  import prf_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned HI_REGS = 4
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       size,
  input  logic             hi,
  input  logic [XLEN-1:0]  word,
  output logic [XLEN-1:0]  data
);
  localparam int unsigned B = BYTE_BITS;
  localparam int unsigned H = HALF_BITS;
  localparam int unsigned W = WORD_BITS;

  always_comb begin
    data = '0;
    unique case (prf_size_e'(size))
      SZ_Q: data = word;
      SZ_W: data[W-1:0] = word[W-1:0];
      SZ_H: data[H-1:0] = word[H-1:0];
      SZ_B: begin
        if (!hi) data[B-1:0] = word[B-1:0];
        else if (int'(idx) < int'(HI_REGS)) data[B-1:0] = word[H-1:B];
      end
      default: data = '0;
    endcase
  end
endmodule

// File: rtl/prf_regfile.sv
module prf_regfile #(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned HI_REGS  = 4,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_size,
  input  logic             wr_hi,
  input  logic [XLEN-1:0]  wr_data,
  output logic             wr_err,
  input  logic [IDX_W-1:0] rd0_idx,
  input  logic [1:0]       rd0_size,
  input  logic             rd0_hi,
  output logic [XLEN-1:0]  rd0_data,
  input  logic [IDX_W-1:0] rd1_idx,
  input  logic [1:0]       rd1_size,
  input  logic             rd1_hi,
  output logic [XLEN-1:0]  rd1_data
);
  localparam int unsigned NUM_RD = 2;

  logic [XLEN-1:0]  rf_q [NUM_REGS];
  logic [XLEN-1:0]  merged;
  logic             legal;
  logic [NUM_REGS-1:0] reg_we;
  logic             err_d, err_q;

  prf_write_merge #(.XLEN(XLEN), .IDX_W(IDX_W), .HI_REGS(HI_REGS)) u_merge (
    .idx     (wr_idx),
    .size    (wr_size),
    .hi      (wr_hi),
    .old_val (rf_q[wr_idx]),
    .data    (wr_data),
    .merged  (merged),
    .legal   (legal)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_comb reg_we[i] = wr_en && legal && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rf_q[i] <= '0;
      else if (reg_we[i]) rf_q[i] <= merged;
    end
  end

  always_comb err_d = wr_en && !legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign wr_err = err_q;

  logic [IDX_W-1:0] rd_idx  [NUM_RD];
  logic [1:0]       rd_size [NUM_RD];
  logic             rd_hi   [NUM_RD];
  logic [XLEN-1:0]  rd_data [NUM_RD];

  assign rd_idx[0]  = rd0_idx;
  assign rd_size[0] = rd0_size;
  assign rd_hi[0]   = rd0_hi;
  assign rd_idx[1]  = rd1_idx;
  assign rd_size[1] = rd1_size;
  assign rd_hi[1]   = rd1_hi;

  for (genvar k = 0; k < NUM_RD; k++) begin : g_rd
    prf_read_port #(.XLEN(XLEN), .IDX_W(IDX_W), .HI_REGS(HI_REGS)) u_rd (
      .idx  (rd_idx[k]),
      .size (rd_size[k]),
      .hi   (rd_hi[k]),
      .word (rf_q[rd_idx[k]]),
      .data (rd_data[k])
    );
  end

  assign rd0_data = rd_data[0];
  assign rd1_data = rd_data[1];
endmodule

// File: rtl/prf_regfile_chk.sv
module prf_regfile_chk #(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned HI_REGS  = 4,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [1:0]       wr_size,
  input logic             wr_hi,
  input logic [XLEN-1:0]  wr_data,
  input logic             wr_err,
  input logic [IDX_W-1:0] rd0_idx,
  input logic [1:0]       rd0_size,
  input logic             rd0_hi,
  input logic [XLEN-1:0]  rd0_data,
  input logic [IDX_W-1:0] rd1_idx,
  input logic [1:0]       rd1_size,
  input logic             rd1_hi,
  input logic [XLEN-1:0]  rd1_data
);
  logic bad_wr;
  assign bad_wr = wr_en && (wr_size == 2'b00) && wr_hi && (int'(wr_idx) >= int'(HI_REGS));

  AST_ERR_ON_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> wr_err); // R7

  AST_NO_ERR_ON_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_wr |=> !wr_err); // R13

  AST_REFUSED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_wr && rd0_idx == wr_idx && rd0_size == 2'b11)
    |=> (rd0_idx != $past(rd0_idx) || rd0_size != 2'b11 || rd0_data == $past(rd0_data))); // R7

  AST_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == 2'b11)
    |=> (rd0_idx != $past(wr_idx) || rd0_size != 2'b11 || rd0_data == $past(wr_data))); // R2

  AST_WORD_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == 2'b10)
    |=> (rd0_idx != $past(wr_idx) || rd0_size != 2'b11
         || rd0_data == {{(XLEN-32){1'b0}}, $past(wr_data[31:0])})); // R3

  AST_BYTE_READ_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd1_size == 2'b00) |-> (rd1_data[XLEN-1:8] == '0)); // R8

  AST_HALF_READ_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_size == 2'b01) |-> (rd0_data[XLEN-1:16] == '0)); // R8

  AST_NO_UPPER_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_size == 2'b00 && rd0_hi && int'(rd0_idx) >= int'(HI_REGS)) |-> (rd0_data == '0)); // R9
endmodule

bind prf_regfile prf_regfile_chk #(.XLEN(XLEN), .NUM_REGS(NUM_REGS), .HI_REGS(HI_REGS)) u_chk (.*);

// File: tb/test_prf_regfile.sv
module test_prf_regfile;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [1:0]  wr_size;
  logic        wr_hi;
  logic [63:0] wr_data;
  logic        wr_err;
  logic [3:0]  rd0_idx, rd1_idx;
  logic [1:0]  rd0_size, rd1_size;
  logic        rd0_hi, rd1_hi;
  logic [63:0] rd0_data, rd1_data;

  int n_chk  = 0;
  int n_fail = 0;
  logic [63:0] model [16];

  always #4 clk = ~clk;

  prf_regfile i_prf_regfile (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_hi(wr_hi),
    .wr_data(wr_data), .wr_err(wr_err),
    .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_hi(rd0_hi), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_hi(rd1_hi), .rd1_data(rd1_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] x_read(logic [63:0] v, int idx, int sz, bit hi);
    case (sz)
      3: return v;
      2: return v & 64'h0000_0000_FFFF_FFFF;
      1: return v & 64'h0000_0000_0000_FFFF;
      default: begin
        if (!hi) return v & 64'hFF;
        if (idx < 4) return (v >> 8) & 64'hFF;
        return 64'h0;
      end
    endcase
  endfunction

  function automatic logic [63:0] x_merge(logic [63:0] o, logic [63:0] d, int idx, int sz, bit hi);
    case (sz)
      3: return d;
      2: return d & 64'h0000_0000_FFFF_FFFF;
      1: return (o & ~64'hFFFF) | (d & 64'hFFFF);
      default: begin
        if (!hi) return (o & ~64'hFF) | (d & 64'hFF);
        if (idx < 4) return (o & ~64'hFF00) | ((d & 64'hFF) << 8);
        return o;
      end
    endcase
  endfunction

  function automatic string wtag(int idx, int sz, bit hi);
    case (sz)
      3: return hi ? "R2/R12 full write" : "R2 full write";
      2: return hi ? "R3/R12 word write" : "R3 word write";
      1: return hi ? "R4/R12 half write" : "R4 half write";
      default: return !hi ? "R5 low byte write" : (idx < 4 ? "R6 upper byte write" : "R7 refused write");
    endcase
  endfunction

  task automatic wr(input int idx, input int sz, input bit hi, input logic [63:0] d);
    bit bad;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_size = 2'(sz); wr_hi = hi; wr_data = d;
    rd1_idx = 4'(idx); rd1_size = 2'b11; rd1_hi = 1'b0;
    #1 chk("R10 old value before edge", rd1_data, model[idx]);
    @(negedge clk);
    wr_en = 1'b0;
    bad = (sz == 0) && hi && (idx >= 4);
    model[idx] = x_merge(model[idx], d, idx, sz, hi);
    chk(bad ? "R7 wr_err pulse" : "R7 wr_err low", {63'b0, wr_err}, {63'b0, bad});
    #1 chk(wtag(idx, sz, hi), rd1_data, model[idx]);
    if (bad) begin
      @(negedge clk);
      chk("R7 wr_err one cycle", {63'b0, wr_err}, 64'h0);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_size = '0; wr_hi = 1'b0; wr_data = '0;
    rd0_idx = '0; rd0_size = 2'b11; rd0_hi = 1'b0;
    rd1_idx = '0; rd1_size = 2'b11; rd1_hi = 1'b0;
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 16; i++) begin
      rd0_idx = 4'(i); rd0_size = 2'b11;
      #1 chk("R1 reset clears", rd0_data, 64'h0);
    end
    chk("R1 reset wr_err", {63'b0, wr_err}, 64'h0);

    // R2..R7, R10, R12 sweep over every register, width and flag
    for (int i = 0; i < 16; i++)
      for (int s = 0; s < 4; s++)
        for (int h = 0; h < 2; h++) begin
          logic [63:0] pre, dat;
          pre = {32'hC3A5_0F1E ^ 32'(i * 257), 32'h8421_7BDE ^ 32'(s * 4099 + h)};
          dat = {32'h1357_9BDF + 32'(i * 65537), 32'hFEDC_BA98 - 32'(s * 131 + h * 7)};
          wr(i, 3, 1'b0, pre);
          wr(i, s, h[0], dat);
        end

    // R13 disabled write
    @(negedge clk);
    wr_en = 1'b0; wr_idx = 4'd5; wr_size = 2'b11; wr_hi = 1'b0; wr_data = 64'hDEAD_0000_BEEF_0000;
    @(negedge clk);
    rd0_idx = 4'd5; rd0_size = 2'b11;
    #1 chk("R13 wr_en low keeps register", rd0_data, model[5]);
    chk("R13 wr_en low no error", {63'b0, wr_err}, 64'h0);

    // R8, R9, R11, R12 read sweep with distinct contents
    for (int i = 0; i < 16; i++)
      wr(i, 3, 1'b0, {8'(i), 8'hA1, 8'h5B, 8'h3C, 8'h7E, 8'h92, 8'(8'hC0 + i), 8'h4D});
    for (int i = 0; i < 16; i++)
      for (int s = 0; s < 4; s++)
        for (int h = 0; h < 2; h++) begin
          @(negedge clk);
          rd0_idx = 4'(i);      rd0_size = 2'(s);     rd0_hi = h[0];
          rd1_idx = 4'(15 - i); rd1_size = 2'(3 - s); rd1_hi = ~h[0];
          #1;
          chk((s == 0 && h == 1) ? "R9 upper byte read port0" : "R8 read port0",
              rd0_data, x_read(model[i], i, s, h[0]));
          chk((s == 3 && h == 0) ? "R9 upper byte read port1" : "R11 read port1",
              rd1_data, x_read(model[15 - i], 15 - i, 3 - s, ~h[0]));
        end

    // R1 asynchronous reset mid-cycle
    @(negedge clk);
    #1 rst_n = 1'b0;
    for (int i = 0; i < 16; i++) begin
      rd0_idx = 4'(i); rd0_size = 2'b11; rd0_hi = 1'b0;
      #1 chk("R1 async clear", rd0_data, 64'h0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) model[i] = '0;
    wr(2, 0, 1'b1, 64'h77);
    wr(9, 0, 1'b1, 64'h55);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule